// File: doc/BRIEF.md
# Column-Skipping Carry-Save Array Multiplier

This block multiplies two unsigned operands and returns the full double-width product. The core is a rectangular array of carry-save cells with one row per multiplier bit. No row resolves its own carries: each cell hands its carry straight down to the cell below, and a ripple adder joins the sum and carry vectors left after the last row. The product is registered by default. With `OUT_REG` cleared the block is purely combinational.

The block saves switching activity by idling whole columns of the array. All cells that share one multiplicand bit sit in one column. When that bit is 0, every cell in the column forces its full-adder inputs to zero, so the adder does not toggle. A multiplexer then copies the cell's incoming sum to its outgoing sum. A zero column never produces a carry, so a bypassed cell needs no carry handling. The column carries are still ANDed with their multiplicand bits in front of the final adder, so no stray carry can reach the result. Nothing is lost by bypassing, and the product stays exact for every input pair.

Top module: `skip_array_mult`

## Requirements
- R1: `prod` equals the unsigned product `op_a * op_b`, `WA+WB` bits wide, for every pair of operands.
- R2: Bit j of `op_a` controls column j. When the bit is 0, each cell in that column drives its sum output from its sum input, and its full-adder inputs are forced to 0.
- R3: The carry entering any cell of a column whose `op_a` bit is 0 is 0.
- R4: Each carry of the last row is ANDed with its column's `op_a` bit before it enters the final adder. A bypassed column therefore adds nothing there.
- R5: The final adder never produces a carry out of its top bit.
- R6: With `OUT_REG=1`, `prod` shows the product of the operands sampled at the previous rising clock edge. With `OUT_REG=0`, `prod` follows the operands within the same cycle.
- R7: A zero operand gives a zero product. All-ones operands give (2^WA-1)(2^WB-1).
- R8: With `OUT_REG=1`, an active-low `rst_n` clears `prod` to 0 asynchronously, whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | WA | Multiplicand; its bits enable the array columns |
| op_b | input | WB | Multiplier; one array row per bit |
| prod | output | WA+WB | Unsigned product |

## Verification
Operands with sparse multiplicands, such as alternating bits and single-bit values, bypass most columns while the multiplier is all ones, which gives the most carries. A design that dropped a carry in a bypassed cell, or let an unmasked stale carry through, would return a product that is too small or too large by a power of two. The all-ones pair loads every cell and the top of the final adder, so a truncated or overflowing adder would lose the top product bit. An exhaustive sweep at the default size and random pairs at an unequal 8x6 size catch wrong carry alignment at the edge columns. Resets asserted with nonzero operands catch an output register that is reset synchronously or never cleared.

// File: rtl/skm_pkg.sv
package skm_pkg;

    localparam int DEF_WA = 4;
    localparam int DEF_WB = 4;

    typedef struct packed {
        logic c;
        logic s;
    } fa_out_t;

    function automatic fa_out_t full_add(input logic x, input logic y, input logic z);
        fa_out_t r;
        r.s = x ^ y ^ z;
        r.c = (x & y) | (z & (x ^ y));
        return r;
    endfunction

endpackage

// File: rtl/skm_cell.sv
module skm_cell (
    input  logic col_en,
    input  logic row_bit,
    input  logic s_in,
    input  logic c_in,
    output logic s_out,
    output logic c_out
);
    import skm_pkg::*;

    logic    pp;
    logic    gs;
    logic    gc;
    fa_out_t fa;

    // R2: freeze the adder inputs of an idle column at zero
    assign pp = col_en & row_bit;
    assign gs = col_en & s_in;
    assign gc = col_en & c_in;
    assign fa = full_add(pp, gs, gc);

    // R2: an idle column forwards the incoming sum unchanged
    assign s_out = col_en ? fa.s : s_in;
    assign c_out = fa.c;

endmodule

// File: rtl/skm_array.sv
module skm_array #(
    parameter int WA = skm_pkg::DEF_WA,
    parameter int WB = skm_pkg::DEF_WB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [WA-1:0] op_a,
    input  logic [WB-1:0] op_b,
    output logic [WB-1:0] lo_bits,
    output logic [WA-2:0] sum_hi,
    output logic [WA-1:0] car_hi
);
    localparam int LAST = WB - 1;

    logic [WB-1:0][WA-1:0] s_row;
    logic [WB-1:0][WA-1:0] c_row;

    // first row: plain partial products, no carries
    assign s_row[0] = op_a & {WA{op_b[0]}};
    assign c_row[0] = '0;

    for (genvar i = 1; i < WB; i++) begin : g_row
        for (genvar j = 0; j < WA; j++) begin : g_col
            logic s_feed;
            if (j == WA - 1) begin : g_top
                assign s_feed = 1'b0;
            end else begin : g_mid
                assign s_feed = s_row[i-1][j+1];
            end

            skm_cell u_cell (
                .col_en (op_a[j]),
                .row_bit(op_b[i]),
                .s_in   (s_feed),
                .c_in   (c_row[i-1][j]),
                .s_out  (s_row[i][j]),
                .c_out  (c_row[i][j])
            );

            p_col_cin_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
                !op_a[j] |-> (c_row[i-1][j] == 1'b0))
                else $error("R3: carry into idle column %0d row %0d", j, i);

            p_col_cout_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
                !op_a[j] |-> (c_row[i][j] == 1'b0))
                else $error("R3: idle column %0d row %0d emitted a carry", j, i);
        end
    end

    for (genvar i = 0; i < WB; i++) begin : g_lo
        assign lo_bits[i] = s_row[i][0];
    end

    assign sum_hi = s_row[LAST][WA-1:1];
    // R4: mask carries of idle columns ahead of the final adder
    assign car_hi = c_row[LAST] & op_a;

endmodule

// File: rtl/skm_cpa.sv
module skm_cpa #(
    parameter int W = skm_pkg::DEF_WA
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W:0] cy;

    assign cy[0] = 1'b0;

    for (genvar k = 0; k < W; k++) begin : g_bit
        skm_pkg::fa_out_t r;
        assign r       = skm_pkg::full_add(x[k], y[k], cy[k]);
        assign s[k]    = r.s;
        assign cy[k+1] = r.c;
    end

    assign co = cy[W];

endmodule

// File: rtl/skip_array_mult.sv
module skip_array_mult #(
    parameter int WA      = skm_pkg::DEF_WA,
    parameter int WB      = skm_pkg::DEF_WB,
    parameter bit OUT_REG = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WA-1:0]      op_a,
    input  logic [WB-1:0]      op_b,
    output logic [WA+WB-1:0]   prod
);
    localparam int PW = WA + WB;

    logic [WB-1:0] lo_bits;
    logic [WA-2:0] sum_hi;
    logic [WA-1:0] car_hi;
    logic [WA-1:0] hi_bits;
    logic          cpa_co;
    logic [PW-1:0] prod_d;

    skm_array #(.WA(WA), .WB(WB)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_a   (op_a),
        .op_b   (op_b),
        .lo_bits(lo_bits),
        .sum_hi (sum_hi),
        .car_hi (car_hi)
    );

    skm_cpa #(.W(WA)) u_cpa (
        .x ({1'b0, sum_hi}),
        .y (car_hi),
        .s (hi_bits),
        .co(cpa_co)
    );

    assign prod_d = {hi_bits, lo_bits};

    p_cpa_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpa_co == 1'b0)
        else $error("R5: final adder overflowed");

    p_zero_operand_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_a == '0) || (op_b == '0)) |-> (prod_d == '0))
        else $error("R7: zero operand gave nonzero product");

    if (OUT_REG) begin : g_reg
        logic [PW-1:0] prod_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prod_q <= '0;
            else        prod_q <= prod_d;
        end

        assign prod = prod_q;

        p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (prod == (PW'($past(op_a)) * PW'($past(op_b)))))
            else $error("R6: registered product wrong");
    end else begin : g_comb
        assign prod = prod_d;

        p_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
            prod == (PW'(op_a) * PW'(op_b)))
            else $error("R1: product wrong");
    end

endmodule

// File: tb/test_skip_array_mult.sv
`timescale 1ns/1ps
module test_skip_array_mult;

    localparam int NA = 4;
    localparam int NB = 4;
    localparam int XA = 8;
    localparam int XB = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [NA-1:0]    a;
    logic [NB-1:0]    b;
    logic [NA+NB-1:0] p;
    logic [XA-1:0]    wa;
    logic [XB-1:0]    wb;
    logic [XA+XB-1:0] wp;

    skip_array_mult #(.WA(NA), .WB(NB), .OUT_REG(1'b1)) i_skip_array_mult (
        .clk(clk), .rst_n(rst_n), .op_a(a), .op_b(b), .prod(p)
    );

    skip_array_mult #(.WA(XA), .WB(XB), .OUT_REG(1'b0)) i_skip_array_mult_w (
        .clk(clk), .rst_n(rst_n), .op_a(wa), .op_b(wb), .prod(wp)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    longint unsigned exp_q[$];
    string           tag_q[$];
    string           wtag = "R1 wide";

    task automatic check(input string req, input longint unsigned act, input longint unsigned expv);
        n_vec++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, expv);
        end
    endtask

    // one clock: compare both outputs, then present new operands
    task automatic step(input logic [NA-1:0] na, input logic [NB-1:0] nb, input string tag,
                        input logic [XA-1:0] nwa, input logic [XB-1:0] nwb, input string ntag);
        longint unsigned e;
        string t;
        @(negedge clk);
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, p, e);
        end
        check(wtag, wp, longint'(wa) * longint'(wb));
        a = na; b = nb; wa = nwa; wb = nwb; wtag = ntag;
        exp_q.push_back(longint'(na) * longint'(nb));
        tag_q.push_back(tag);
    endtask

    initial begin
        a = '0; b = '0; wa = '0; wb = '0;
        repeat (3) begin
            @(negedge clk);
            check("R8 reset value", p, 0);
        end
        rst_n = 1'b1;

        // corners
        step(4'h0, 4'h0, "R7 zero both", 8'hFF, 6'h3F, "R5 R7 wide all-ones");
        step(4'hF, 4'hF, "R5 R7 all-ones", 8'h00, 6'h3F, "R7 wide zero a");
        step(4'hF, 4'h0, "R7 zero b", 8'hFF, 6'h00, "R7 wide zero b");
        step(4'h0, 4'hF, "R7 zero a", 8'h80, 6'h3F, "R2 wide top column only");
        // idle columns under a full multiplier
        step(4'hA, 4'hF, "R2 R3 alternating a", 8'h55, 6'h3F, "R3 R4 wide alternating");
        step(4'h5, 4'hF, "R2 R3 alternating a", 8'hAA, 6'h3F, "R3 R4 wide alternating");
        step(4'h1, 4'hF, "R4 single low column", 8'h01, 6'h3F, "R4 wide low column");
        step(4'h8, 4'hF, "R4 single top column", 8'h81, 6'h2A, "R2 wide edge columns");
        // R1 exhaustive sweep, R6 latency checked on every vector
        for (int i = 0; i < 256; i++) begin
            logic [XA-1:0] ra;
            logic [XB-1:0] rb;
            ra = XA'($urandom);
            rb = XB'($urandom);
            if (i % 3 == 0) ra = ra & XA'($urandom);
            step(NA'(i >> NB), NB'(i), "R1 R6 sweep", ra, rb,
                 (i % 3 == 0) ? "R3 wide sparse" : "R1 R6 wide random");
        end
        step(4'h0, 4'h0, "R1 flush", 8'h00, 6'h00, "R1 flush");
        @(negedge clk);
        if (exp_q.size() > 0) check(tag_q.pop_front(), p, exp_q.pop_front());
        check(wtag, wp, longint'(wa) * longint'(wb));

        // R8: reset with nonzero operands clears without a clock edge
        a = 4'hF; b = 4'hD;
        @(negedge clk);
        @(negedge clk);
        check("R6 held operands", p, 15 * 13);
        #1 rst_n = 1'b0;
        #0.5 check("R8 async clear", p, 0);
        @(negedge clk);
        check("R8 held in reset", p, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 after reset", p, 15 * 13);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule